// File: doc/BRIEF.md
# Table-Lookup Sequential Bit Counter

This block reports how many bits are set in a wide data word that arrives at a slow, regular rate, while the block itself runs on a much faster clock. The word is cut into 12-bit slices. Each slice addresses a small lookup table that holds the one-count of every possible address. Each table instance has two read ports, so one instance serves two slices. Every instance is computed when the design is elaborated.

A time-multiplexed accumulator adds the per-slice counts, one per fast-clock cycle. Any bits above the last whole pair of slices are counted by a small adder chain. That adder result is the accumulator's starting value.

A new word is offered with a one-cycle valid strobe. The count is returned with a one-cycle valid pulse a fixed number of cycles later, well inside the word period. A strobe that arrives while a count is still in progress is dropped, and it sets a sticky overrun flag.

Top module: `popcnt_rom_seq`

## Requirements
- R1: Synchronous active-low reset clears the count output to 0, the count-valid output to 0 and the overrun flag to 0.
- R2: For every accepted 150-bit word, the reported count equals the number of ones in that word. The count output is 8 bits, with a largest value of 150.
- R3: Count-valid is high for exactly one cycle. It rises exactly 13 fast-clock cycles after the rising edge that accepted the word: one cycle of capture, one cycle of table read, then 12 accumulation steps.
- R4: Bits 149 down to 144 lie above the twelve 12-bit slices and are still counted. A word with only those bits set reports 6, and a word with only bit 144 set reports 1.
- R5: Slice k covers bits 12k+11 down to 12k for k = 0..11. Bits at slice edges (0, 11, 12, 143) are each counted once, and an all-ones word reports 150.
- R6: A word-valid strobe sampled while a count is in progress sets the overrun flag on the next edge. The flag then stays set until reset.
- R7: A word offered while a count is in progress is ignored. No extra count-valid pulse appears, and the count in progress reports the earlier word.
- R8: A word offered in the cycle where count-valid is high is accepted. Its result appears 13 cycles after its accepting edge.
- R9: The count output holds its value in every cycle in which count-valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast accumulation clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld | input | 1 | One-cycle strobe: a new word is on word_data |
| word_data | input | 150 | Word whose set bits are counted |
| cnt_vld | output | 1 | One-cycle pulse: cnt holds a new result |
| cnt | output | 8 | Number of set bits in the last accepted word |
| overrun | output | 1 | Sticky: a word arrived while a count was in progress |

## Verification
The block is driven with several kinds of word:
- All-zero and all-ones words bound the count range.
- Words that touch only the leftover bits, or only slice-edge bits, show whether the slice map and the starting value are wired correctly.
- Alternating and random words exercise the adder path with mixed partial counts.

A scoreboard records the expected count and the expected cycle of each result. This separates a wrong sum from a wrong latency.

Timing cases are tried separately:
- A second word offered in the result cycle shows that back-to-back acceptance works.
- A word offered mid-count shows that the word is dropped and the overrun flag is set.

// File: rtl/popcnt_pkg.sv
// Shared types for the table-lookup bit counter.
// Assumes nothing beyond a single fast clock domain.
package popcnt_pkg;

    // Sequencer states of the accumulator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a word
        ST_LOAD = 2'd1,   // table outputs settling, load starting value
        ST_SUM  = 2'd2    // one partial count added per cycle
    } seq_state_t;

endpackage

// File: rtl/popcnt_rom2.sv
// Dual-read lookup table: each entry holds the number of ones in its address.
// The contents are computed at elaboration by a constant function.
// Both reads are registered, which gives one cycle of read latency.
// Assumes DATA_W is wide enough to hold ADDR_W.
module popcnt_rom2 #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic [DATA_W-1:0] dout_a,
    output logic [DATA_W-1:0] dout_b
);
    localparam int DEPTH = 1 << ADDR_W;

    // Build the table image: entry i is the one-count of i
    function automatic logic [DEPTH*DATA_W-1:0] build_table();
        logic [DEPTH*DATA_W-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) begin
            img[i*DATA_W +: DATA_W] = DATA_W'($countones(ADDR_W'(i)));
        end
        return img;
    endfunction

    localparam logic [DEPTH*DATA_W-1:0] TABLE = build_table();

    // Registered read, port A
    always_ff @(posedge clk) begin
        dout_a <= TABLE[addr_a*DATA_W +: DATA_W];
    end

    // Registered read, port B
    always_ff @(posedge clk) begin
        dout_b <= TABLE[addr_b*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/popcnt_tail.sv
// Combinational one-counter for the few bits that lie above the last slice.
// Its result seeds the accumulator. Assumes W is small (a plain adder chain).
module popcnt_tail #(
    parameter int W     = 6,
    parameter int OUT_W = 8
) (
    input  logic [W-1:0]     bits,
    output logic [OUT_W-1:0] ones
);
    // Ripple sum of the leftover bits
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + OUT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/popcnt_accum.sv
// Sequencer and accumulator.
// On an accepted word it waits one cycle for the table reads and loads the
// leftover count. It then adds one partial count per cycle and emits the
// total with a one-cycle valid pulse.
// Assumes the partial counts are stable from the LOAD cycle through the last step.
module popcnt_accum
    import popcnt_pkg::*;
#(
    parameter int NPART  = 12,
    parameter int PART_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              word_vld,
    input  logic [CNT_W-1:0]                  tail_cnt,
    input  logic [NPART-1:0][PART_W-1:0]      parts,
    output logic                              take,
    output logic                              busy,
    output logic [CNT_W-1:0]                  cnt,
    output logic                              cnt_vld,
    output logic                              overrun
);
    localparam int STEP_W = (NPART > 1) ? $clog2(NPART) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NPART - 1);

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  acc;
    logic [CNT_W-1:0]  acc_next;

    assign busy     = (state != ST_IDLE);
    assign take     = word_vld && !busy;
    assign acc_next = acc + CNT_W'(parts[step]);

    // State, step counter and accumulator sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            acc     <= '0;
            cnt     <= '0;
            cnt_vld <= 1'b0;
        end else begin
            cnt_vld <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    acc   <= tail_cnt;
                    step  <= '0;
                    state <= ST_SUM;
                end
                ST_SUM: begin
                    acc  <= acc_next;
                    step <= step + 1'b1;
                    if (step == LAST_STEP) begin
                        cnt     <= acc_next;
                        cnt_vld <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky overrun: a word strobe seen while busy
    always_ff @(posedge clk) begin
        if (!rst_n)             overrun <= 1'b0;
        else if (word_vld && busy) overrun <= 1'b1;
    end

endmodule

// File: rtl/popcnt_rom_seq.sv
// Top: counts the set bits of a wide word using registered lookup tables
// on 12-bit slices and a time-multiplexed accumulator.
// Slices are taken in whole pairs from bit 0 upward. Bits above them go to
// the leftover counter. Assumes words arrive no faster than one per
// (slice count + 2) cycles.
module popcnt_rom_seq
    import popcnt_pkg::*;
#(
    parameter int WORD_W  = 150,
    parameter int SLICE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [149:0]      word_data,
    output logic              cnt_vld,
    output logic [7:0]        cnt,
    output logic              overrun
);
    localparam int NUM_ROMS   = (WORD_W / SLICE_W) / 2;
    localparam int NUM_SLICES = 2 * NUM_ROMS;
    localparam int LEFT_W     = WORD_W - NUM_SLICES * SLICE_W;
    localparam int PART_W     = $clog2(SLICE_W + 1);
    localparam int CNT_W      = $clog2(WORD_W + 1);

    logic [WORD_W-1:0]                 word_q;
    logic [NUM_SLICES-1:0][PART_W-1:0] parts;
    logic [CNT_W-1:0]                  tail_cnt;
    logic                              take;
    logic                              busy;

    // Capture the word when the sequencer accepts it
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (take) word_q <= word_data;
    end

    // One dual-read table per pair of slices
    for (genvar r = 0; r < NUM_ROMS; r++) begin : g_rom
        popcnt_rom2 #(
            .ADDR_W (SLICE_W),
            .DATA_W (PART_W)
        ) u_rom (
            .clk    (clk),
            .addr_a (word_q[(2*r)*SLICE_W   +: SLICE_W]),
            .addr_b (word_q[(2*r+1)*SLICE_W +: SLICE_W]),
            .dout_a (parts[2*r]),
            .dout_b (parts[2*r+1])
        );
    end

    // Leftover bits above the slices, or zero when none remain
    if (LEFT_W > 0) begin : g_tail
        popcnt_tail #(
            .W     (LEFT_W),
            .OUT_W (CNT_W)
        ) u_tail (
            .bits (word_q[WORD_W-1 -: LEFT_W]),
            .ones (tail_cnt)
        );
    end else begin : g_no_tail
        assign tail_cnt = '0;
    end

    popcnt_accum #(
        .NPART  (NUM_SLICES),
        .PART_W (PART_W),
        .CNT_W  (CNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .tail_cnt (tail_cnt),
        .parts    (parts),
        .take     (take),
        .busy     (busy),
        .cnt      (cnt),
        .cnt_vld  (cnt_vld),
        .overrun  (overrun)
    );

endmodule

// File: rtl/popcnt_rom_seq_chk.sv
// Property checker for popcnt_rom_seq, attached with bind.
// It watches ports and the busy flag. It tracks latency with its own counter.
module popcnt_rom_seq_chk #(
    parameter int WORD_W    = 150,
    parameter int NUM_STEPS = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       word_vld,
    input logic       busy,
    input logic       cnt_vld,
    input logic [7:0] cnt,
    input logic       overrun
);
    logic [7:0] since_take;

    // Cycles since the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_take <= '0;
        else if (word_vld && !busy) since_take <= 8'd1;
        else if (since_take != 0)   since_take <= since_take + 8'd1;
    end

    // R1: reset clears outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!cnt_vld && !overrun && cnt == 8'd0));

    // R2: count never exceeds the word width
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_vld |-> (cnt <= 8'(WORD_W)));

    // R3: valid is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_vld |=> !cnt_vld);

    // R3: result arrives a fixed number of cycles after acceptance
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_vld |-> (since_take == 8'(NUM_STEPS + 2)));

    // R6: a strobe while busy sets the flag
    a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && busy) |=> overrun);

    // R6: the flag is sticky
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9: the count holds between pulses
    a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_vld |-> $stable(cnt));

endmodule

bind popcnt_rom_seq popcnt_rom_seq_chk #(
    .WORD_W    (WORD_W),
    .NUM_STEPS (NUM_SLICES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .busy     (busy),
    .cnt_vld  (cnt_vld),
    .cnt      (cnt),
    .overrun  (overrun)
);

// File: tb/test_popcnt_rom_seq.sv
// Scoreboard bench for popcnt_rom_seq. The driver queues the expected count
// and the result cycle. The monitor pops and compares on every pulse.
module test_popcnt_rom_seq;
    localparam int LAT_NEG = 14;   // negedges from drive to pulse (13 edges after accept)

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         word_vld = 1'b0;
    logic [149:0] word_data = '0;
    logic         cnt_vld;
    logic [7:0]   cnt;
    logic         overrun;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int exp_cnt_q[$];
    int exp_cyc_q[$];
    int last_cnt = 0;

    popcnt_rom_seq i_popcnt_rom_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .word_data (word_data),
        .cnt_vld   (cnt_vld),
        .cnt       (cnt),
        .overrun   (overrun)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare every result pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n && cnt_vld) begin
            if (exp_cnt_q.size() == 0) begin
                check(1'b0, "R7 unexpected result pulse", int'(cnt), -1);
            end else begin
                int ec, ey;
                ec = exp_cnt_q.pop_front();
                ey = exp_cyc_q.pop_front();
                check(int'(cnt) == ec, "R2 count value", int'(cnt), ec);
                check(cyc == ey, "R3 result cycle", cyc, ey);
                last_cnt = ec;
            end
        end
    end

    // Driver: offer one word; queue its expectation when it should be taken
    task automatic send(input logic [149:0] d, input bit accept);
        word_data = d;
        word_vld  = 1'b1;
        if (accept) begin
            exp_cnt_q.push_back($countones(d));
            exp_cyc_q.push_back(cyc + LAT_NEG);
        end
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    task automatic drain();
        repeat (18) @(negedge clk);
    endtask

    function automatic logic [149:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [149:0] w;
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cnt == 8'd0, "R1 cnt after reset", int'(cnt), 0);
        check(cnt_vld == 1'b0, "R1 cnt_vld after reset", int'(cnt_vld), 0);
        check(overrun == 1'b0, "R1 overrun after reset", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        send('0, 1'b1); drain();                       // R2 zero word
        send({150{1'b1}}, 1'b1); drain();              // R5 all ones -> 150
        w = '0; w[149:144] = 6'h3f;
        send(w, 1'b1); drain();                        // R4 leftover only -> 6
        w = '0; w[144] = 1'b1;
        send(w, 1'b1); drain();                        // R4 bit 144 -> 1
        w = '0; w[0] = 1'b1; w[11] = 1'b1; w[12] = 1'b1; w[143] = 1'b1;
        send(w, 1'b1); drain();                        // R5 slice edges -> 4
        send({75{2'b01}}, 1'b1); drain();              // R2 alternating -> 75
        for (int i = 0; i < 4; i++) begin
            send(rnd_word(), 1'b1); drain();           // R2 random words
        end

        // R8: second word offered in the pulse cycle
        send(rnd_word(), 1'b1);
        repeat (LAT_NEG - 1) @(negedge clk);
        check(cnt_vld == 1'b1, "R8 pulse before back-to-back word", int'(cnt_vld), 1);
        send({150{1'b1}}, 1'b1);
        drain();

        // R9: count holds after the pulse
        held = int'(cnt);
        repeat (6) @(negedge clk);
        check(int'(cnt) == held, "R9 count holds", int'(cnt), held);
        check(held == last_cnt, "R9 held value is last result", held, last_cnt);

        // R6 / R7: word during a count is dropped and flagged
        check(overrun == 1'b0, "R6 overrun clear before test", int'(overrun), 0);
        w = '0; w[5:0] = 6'h3f;
        send(w, 1'b1);
        repeat (3) @(negedge clk);
        send({150{1'b1}}, 1'b0);
        check(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
        drain();
        check(exp_cnt_q.size() == 0, "R7 dropped word produced no result", exp_cnt_q.size(), 0);
        check(int'(cnt) == 6, "R7 result is earlier word", int'(cnt), 6);
        repeat (5) @(negedge clk);
        check(overrun == 1'b1, "R6 overrun sticky", int'(overrun), 1);
        send(rnd_word(), 1'b1); drain();               // accepted again after the drop

        // R1: reset clears the sticky flag and outputs
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(overrun == 1'b0, "R1 overrun cleared by reset", int'(overrun), 0);
        check(cnt == 8'd0, "R1 cnt cleared by reset", int'(cnt), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        check(exp_cnt_q.size() == 0, "R2 all expected results seen", exp_cnt_q.size(), 0);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule